// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep and Wake-Up

This block turns an asynchronous serial line into characters. A baud tick strobe arrives sixteen times per bit period. On each strobe the block samples the line and finds the start edge. It takes each bit by a vote of three samples around the bit centre. The data field is 8 or 9 bits long and arrives least significant bit first. One stop bit follows the data field. When parity checking is on, the top bit of the data field carries the parity bit. The check covers the bits below it. The line comes either from the external pin or, in loop mode, from an internal transmitter output.

A receiver in a multi-drop network can be put to sleep so that it ignores traffic meant for other nodes. While the receiver sleeps its data and status flags are frozen. Hardware wakes it up in one of two ways. In idle mode it wakes when an idle line is seen. In address mode it wakes on a character whose top data bit is 1, and that character is delivered as normal data. Two rules decide when idle counting starts. In the short rule, consecutive high samples count from the start bit onward, data bits included. In the long rule, counting begins only when the frame has finished. The receive interrupt is the logical AND of its enable with either of two flags: data-full or overrun.

Top module: `serial_rx_wake`

## Requirements
- R1: With `cfg_loop`=1 the receiver reads `loop_tx`, and activity on `rxd_pin` produces no character. With `cfg_loop`=0 it reads `rxd_pin`.
- R2: A frame is a 0 start bit, then the data bits LSB first, then a stop bit. With `cfg_long_char`=0 there are 8 data bits and `rx_data[8]` reads 0. With `cfg_long_char`=1 there are 9 data bits. A completed frame sets `rdrf` and loads `rx_data`.
- R3: A start edge counts only if the line is still low at the eighth tick of the start bit. A shorter low pulse produces no character. Each bit value is the majority of ticks 7, 8 and 9 of its 16.
- R4: With `cfg_par_en`=1 the top data bit is the parity bit. `pe_err` is set with `rdrf` when the XOR of all data bits differs from `cfg_par_odd` (0 = even, 1 = odd). `pe_err` never stands without `rdrf`.
- R5: A stop bit sampled as 0 sets `fe_err` along with `rdrf`. The data is still loaded.
- R6: If a frame completes while `rdrf` is set and no read happens in that cycle, `ovr` is set. `rx_data`, `fe_err` and `pe_err` then keep their values, and the new character is dropped.
- R7: `rx_irq` = `cfg_rie` AND (`rdrf` OR `ovr`).
- R8: The line counts as idle after 10 bit times of ones with the 8-bit format, or 11 with the 9-bit format. With `cfg_idle_long`=0 the ones are counted from the start bit onward. With `cfg_idle_long`=1 they are counted only after the frame ends. `idle` is raised once per idle period, and only after a start bit has been seen since the last one.
- R9: While `rwu`=1, completed frames do not set `rdrf` or load data, and an idle period does not set `idle`. The only exception is the waking character of R11. A one-cycle pulse on `rwu_set` sets `rwu`.
- R10: With `cfg_wake_addr`=0, a detected idle period clears `rwu`.
- R11: With `cfg_wake_addr`=1, a character whose top data bit is 1 clears `rwu` and is loaded like normal data. Data bit 7 is the top bit in the 8-bit format and data bit 8 in the 9-bit format. An idle period does not clear `rwu` in this mode.
- R12: Reset clears every output to 0. A one-cycle `data_read` pulse clears `rdrf`, `ovr`, `fe_err`, `pe_err` and `idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd_pin | input | 1 | External serial line |
| loop_tx | input | 1 | Internal transmitter output used in loop mode |
| cfg_loop | input | 1 | 1 = read `loop_tx` |
| cfg_long_char | input | 1 | 1 = 9 data bits, 0 = 8 |
| cfg_wake_addr | input | 1 | 1 = wake on address mark, 0 = wake on idle |
| cfg_idle_long | input | 1 | 1 = count idle only after the frame ends |
| cfg_par_en | input | 1 | Enable parity checking |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_rie | input | 1 | Receive interrupt enable |
| rwu_set | input | 1 | Pulse to put the receiver to sleep |
| data_read | input | 1 | Pulse: data taken, clear flags |
| rx_data | output | DMAX | Received data field |
| rdrf | output | 1 | Receive data full |
| ovr | output | 1 | Overrun |
| idle | output | 1 | Idle line seen |
| fe_err | output | 1 | Framing error |
| pe_err | output | 1 | Parity error |
| rwu | output | 1 | Receiver asleep |
| rx_irq | output | 1 | Masked receive interrupt |

## Verification
The two idle-counting rules are checked in time: with the short rule an all-ones character must raise `idle` by 13 bit times after its start bit, and with the long rule it must not raise it until after the frame has ended. A design that counted from the wrong point would flag late under the short rule or early under the long rule. Three more cases are driven:
- A low glitch shorter than half a bit must not create a character. A receiver that skipped start validation would deliver a spurious 0xFF.
- A second character that arrives before the first is read must set `ovr` and leave the first character in place. A receiver that got this wrong would show the second value.
- Sleep is exercised in both wake modes. A receiver with the wrong wake rule would either load the unaddressed character or stay asleep after the address mark.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      FR_HUNT  = 2'd0,
      FR_START = 2'd1,
      FR_DATA  = 2'd2,
      FR_STOP  = 2'd3
   } frame_state_t;

   // XOR of the first nbits bits of the field, compared with the parity sense.
   // Returns 1 when the parity bit held in the field does not match.
   function automatic logic parity_mismatch(input logic [15:0] field,
                                            input int unsigned nbits,
                                            input logic odd_sense);
      logic acc;
      acc = odd_sense;
      for (int i = 0; i < 16; i++) begin
         if (i < nbits) acc = acc ^ field[i];
      end
      return acc;
   endfunction

endpackage

// File: rtl/srx_line_sel.sv
module srx_line_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_loop,
   input  logic pin_in,
   input  logic loop_in,
   output logic line_o
);
   logic raw_line;
   assign raw_line = sel_loop ? loop_in : pin_in;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign line_o = raw_line;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '1;
            end else begin
               stage_q[0] <= raw_line;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign line_o = stage_q[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import serial_rx_pkg::*;
#(
   parameter int OVS  = 16,
   parameter int DMAX = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            line,
   input  logic            long_char,
   output logic            busy,
   output logic            start_ok,
   output logic            done,
   output logic            stop_bit,
   output logic [DMAX-1:0] frame_data
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DMAX + 1);
   localparam logic [CW-1:0] C_LAST   = CW'(OVS - 1);
   localparam logic [CW-1:0] C_VOTE_A = CW'(OVS / 2 - 2);
   localparam logic [CW-1:0] C_VOTE_B = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] C_VOTE_C = CW'(OVS / 2);
   localparam logic [CW-1:0] C_START  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] C_STOP   = CW'(OVS / 2 + 1);
   localparam logic [BW-1:0] B_LONG   = BW'(DMAX - 1);
   localparam logic [BW-1:0] B_SHORT  = BW'(DMAX - 2);

   frame_state_t    state_q;
   logic [CW-1:0]   cnt_q;
   logic [BW-1:0]   bit_q;
   logic [1:0]      votes_q;
   logic [DMAX-1:0] shreg_q;
   logic [BW-1:0]   last_bit;
   logic            in_vote;

   assign last_bit = long_char ? B_LONG : B_SHORT;
   assign in_vote  = (cnt_q == C_VOTE_A) || (cnt_q == C_VOTE_B) || (cnt_q == C_VOTE_C);
   assign busy     = (state_q != FR_HUNT);
   assign frame_data = shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FR_HUNT;
         cnt_q    <= '0;
         bit_q    <= '0;
         votes_q  <= '0;
         shreg_q  <= '0;
         done     <= 1'b0;
         start_ok <= 1'b0;
         stop_bit <= 1'b1;
      end else begin
         done     <= 1'b0;
         start_ok <= 1'b0;
         if (tick) begin
            case (state_q)
               FR_HUNT: begin
                  if (!line) begin
                     state_q <= FR_START;
                     cnt_q   <= CW'(1);
                  end
               end
               FR_START: begin
                  if (cnt_q == C_START && line) begin
                     state_q <= FR_HUNT;
                     cnt_q   <= '0;
                  end else begin
                     if (cnt_q == C_START) start_ok <= 1'b1;
                     if (cnt_q == C_LAST) begin
                        state_q <= FR_DATA;
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        votes_q <= '0;
                        shreg_q <= '0;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               FR_DATA: begin
                  if (in_vote) votes_q <= votes_q + {1'b0, line};
                  if (cnt_q == C_LAST) begin
                     shreg_q[bit_q] <= votes_q[1];
                     votes_q        <= '0;
                     cnt_q          <= '0;
                     if (bit_q == last_bit) state_q <= FR_STOP;
                     else                   bit_q   <= bit_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               FR_STOP: begin
                  if (in_vote) votes_q <= votes_q + {1'b0, line};
                  if (cnt_q == C_STOP) begin
                     done     <= 1'b1;
                     stop_bit <= votes_q[1];
                     state_q  <= FR_HUNT;
                     cnt_q    <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= FR_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/srx_idle_det.sv
module srx_idle_det #(
   parameter int OVS  = 16,
   parameter int DMAX = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic busy,
   input  logic start_ok,
   input  logic long_char,
   input  logic idle_long,
   output logic idle_evt
);
   localparam int LIM_L = (DMAX + 2) * OVS;
   localparam int LIM_S = (DMAX + 1) * OVS;
   localparam int OW    = $clog2(LIM_L + 1);
   localparam logic [OW-1:0] O_LIM_L = OW'(LIM_L);
   localparam logic [OW-1:0] O_LIM_S = OW'(LIM_S);

   logic [OW-1:0] ones_q;
   logic [OW-1:0] limit;
   logic          armed_q;
   logic          countable;

   assign limit     = long_char ? O_LIM_L : O_LIM_S;
   assign countable = line && !(idle_long && busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q   <= '0;
         armed_q  <= 1'b0;
         idle_evt <= 1'b0;
      end else begin
         idle_evt <= 1'b0;
         if (start_ok) armed_q <= 1'b1;
         if (tick) begin
            if (!countable) begin
               ones_q <= '0;
            end else if (ones_q < limit) begin
               ones_q <= ones_q + 1'b1;
               if ((ones_q == limit - 1'b1) && armed_q) begin
                  idle_evt <= 1'b1;
                  armed_q  <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/srx_status.sv
module srx_status
   import serial_rx_pkg::*;
#(
   parameter int DMAX = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            done,
   input  logic            stop_bit,
   input  logic [DMAX-1:0] frame_data,
   input  logic            idle_evt,
   input  logic            long_char,
   input  logic            wake_addr,
   input  logic            par_en,
   input  logic            par_odd,
   input  logic            rwu_set,
   input  logic            data_read,
   output logic [DMAX-1:0] rx_data,
   output logic            rdrf,
   output logic            ovr,
   output logic            idle,
   output logic            fe_err,
   output logic            pe_err,
   output logic            rwu
);
   logic        top_bit;
   logic        accept;
   logic        par_bad;
   int unsigned nbits;

   assign nbits   = long_char ? DMAX : DMAX - 1;
   assign top_bit = long_char ? frame_data[DMAX-1] : frame_data[DMAX-2];
   assign par_bad = par_en && parity_mismatch(16'(frame_data), nbits, par_odd);
   assign accept  = done && (!rwu || (wake_addr && top_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rdrf    <= 1'b0;
         ovr     <= 1'b0;
         idle    <= 1'b0;
         fe_err  <= 1'b0;
         pe_err  <= 1'b0;
         rwu     <= 1'b0;
      end else begin
         if (data_read) begin
            rdrf   <= 1'b0;
            ovr    <= 1'b0;
            idle   <= 1'b0;
            fe_err <= 1'b0;
            pe_err <= 1'b0;
         end
         if (accept) begin
            if (rdrf && !data_read) begin
               ovr <= 1'b1;
            end else begin
               rx_data <= frame_data;
               rdrf    <= 1'b1;
               fe_err  <= !stop_bit;
               pe_err  <= par_bad;
            end
         end
         if (idle_evt && !rwu) idle <= 1'b1;
         if (rwu && ((wake_addr && accept) || (!wake_addr && idle_evt))) rwu <= 1'b0;
         if (rwu_set) rwu <= 1'b1;
      end
   end
endmodule

// File: rtl/serial_rx_wake.sv
module serial_rx_wake #(
   parameter int OVS         = 16,
   parameter int DMAX        = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            baud_tick,
   input  logic            rxd_pin,
   input  logic            loop_tx,
   input  logic            cfg_loop,
   input  logic            cfg_long_char,
   input  logic            cfg_wake_addr,
   input  logic            cfg_idle_long,
   input  logic            cfg_par_en,
   input  logic            cfg_par_odd,
   input  logic            cfg_rie,
   input  logic            rwu_set,
   input  logic            data_read,
   output logic [DMAX-1:0] rx_data,
   output logic            rdrf,
   output logic            ovr,
   output logic            idle,
   output logic            fe_err,
   output logic            pe_err,
   output logic            rwu,
   output logic            rx_irq
);
   generate
      if (OVS < 8)         begin : g_bad_ovs  $error("OVS must be at least 8");          end
      if (DMAX < 3)        begin : g_bad_dmin $error("DMAX must be at least 3");         end
      if (DMAX > 16)       begin : g_bad_dmax $error("DMAX must not exceed 16");         end
      if (SYNC_STAGES < 0) begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic            line;
   logic            busy;
   logic            start_ok;
   logic            done;
   logic            stop_bit;
   logic            idle_evt;
   logic [DMAX-1:0] frame_data;

   srx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk(clk), .rst_n(rst_n), .sel_loop(cfg_loop),
      .pin_in(rxd_pin), .loop_in(loop_tx), .line_o(line)
   );

   srx_framer #(.OVS(OVS), .DMAX(DMAX)) u_framer (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line),
      .long_char(cfg_long_char), .busy(busy), .start_ok(start_ok),
      .done(done), .stop_bit(stop_bit), .frame_data(frame_data)
   );

   srx_idle_det #(.OVS(OVS), .DMAX(DMAX)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line),
      .busy(busy), .start_ok(start_ok), .long_char(cfg_long_char),
      .idle_long(cfg_idle_long), .idle_evt(idle_evt)
   );

   srx_status #(.DMAX(DMAX)) u_stat (
      .clk(clk), .rst_n(rst_n), .done(done), .stop_bit(stop_bit),
      .frame_data(frame_data), .idle_evt(idle_evt),
      .long_char(cfg_long_char), .wake_addr(cfg_wake_addr),
      .par_en(cfg_par_en), .par_odd(cfg_par_odd), .rwu_set(rwu_set),
      .data_read(data_read), .rx_data(rx_data), .rdrf(rdrf), .ovr(ovr),
      .idle(idle), .fe_err(fe_err), .pe_err(pe_err), .rwu(rwu)
   );

   assign rx_irq = cfg_rie && (rdrf || ovr);
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DMAX = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_rie,
   input logic            data_read,
   input logic [DMAX-1:0] rx_data,
   input logic            rdrf,
   input logic            ovr,
   input logic            idle,
   input logic            fe_err,
   input logic            pe_err,
   input logic            rwu,
   input logic            rx_irq
);
   // R4
   pe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_err |-> rdrf);

   // R5
   fe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_err |-> rdrf);

   // R6
   ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> rdrf);

   // R6
   ovr_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !data_read) |=> $stable(rx_data));

   // R7
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rie |-> !rx_irq);

   // R7
   irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rie && (rdrf || ovr)) |-> rx_irq);

   // R9
   sleep_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdrf) |-> (!$past(rwu) || !rwu));

   // R9
   sleep_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> !$past(rwu));
endmodule

bind serial_rx_wake srx_checker #(.DMAX(DMAX)) u_chk (.*);

// File: tb/serial_rx_wake_tb.sv
`timescale 1ns/1ps
module serial_rx_wake_tb;
   localparam int OVS    = 16;
   localparam int DMAX   = 9;
   localparam int TDIV   = 4;
   localparam int BITCLK = OVS * TDIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] tdiv = '0;
   logic baud_tick;
   logic rxd_pin = 1'b1, loop_tx = 1'b1;
   logic cfg_loop = 0, cfg_long_char = 0, cfg_wake_addr = 0, cfg_idle_long = 0;
   logic cfg_par_en = 0, cfg_par_odd = 0, cfg_rie = 0;
   logic rwu_set = 0, data_read = 0;
   logic [DMAX-1:0] rx_data;
   logic rdrf, ovr, idle, fe_err, pe_err, rwu, rx_irq;

   typedef struct packed { logic [8:0] d; logic pe; logic fe; } exp_t;
   exp_t sb[$];
   int  n_chk = 0, n_bad = 0;
   bit  auto_rd = 0;
   bit  ended = 0;

   always #2.5 clk = ~clk;
   always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
   assign baud_tick = &tdiv;

   serial_rx_wake #(.OVS(OVS), .DMAX(DMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd_pin(rxd_pin),
      .loop_tx(loop_tx), .cfg_loop(cfg_loop), .cfg_long_char(cfg_long_char),
      .cfg_wake_addr(cfg_wake_addr), .cfg_idle_long(cfg_idle_long),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_rie(cfg_rie),
      .rwu_set(rwu_set), .data_read(data_read), .rx_data(rx_data),
      .rdrf(rdrf), .ovr(ovr), .idle(idle), .fe_err(fe_err), .pe_err(pe_err),
      .rwu(rwu), .rx_irq(rx_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wait_bits(input int b);
      repeat (b * BITCLK) @(negedge clk);
   endtask

   task automatic pulse_read();
      @(negedge clk) data_read = 1'b1;
      @(negedge clk) data_read = 1'b0;
   endtask

   task automatic pulse_sleep();
      @(negedge clk) rwu_set = 1'b1;
      @(negedge clk) rwu_set = 1'b0;
   endtask

   task automatic set_line(input bit to_loop, input logic v);
      if (to_loop) loop_tx = v;
      else         rxd_pin = v;
   endtask

   // Driver: builds the field, pushes the expected item, drives the frame.
   task automatic send(input logic [8:0] val, input bit pen, input bit podd,
                       input bit badp, input bit stopv, input bit to_loop,
                       input bit push);
      int n;
      logic [8:0] field;
      logic p;
      exp_t e;
      n = cfg_long_char ? 9 : 8;
      field = cfg_long_char ? val : {1'b0, val[7:0]};
      if (pen) begin
         p = podd;
         for (int i = 0; i < n - 1; i++) p = p ^ field[i];
         if (badp) p = ~p;
         field[n-1] = p;
      end
      e.d = field; e.pe = pen & badp; e.fe = ~stopv;
      if (push) sb.push_back(e);
      @(negedge clk);
      set_line(to_loop, 1'b0);
      wait_bits(1);
      for (int i = 0; i < n; i++) begin
         set_line(to_loop, field[i]);
         wait_bits(1);
      end
      set_line(to_loop, stopv);
      wait_bits(1);
      set_line(to_loop, 1'b1);
   endtask

   // Monitor: pops the scoreboard whenever a character is delivered.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (auto_rd && rdrf) begin
            if (sb.size() == 0) begin
               chk("R2 unexpected char", {23'd0, rx_data}, 32'hFFFF_FFFF);
            end else begin
               e = sb.pop_front();
               chk("R2 data", {23'd0, rx_data}, {23'd0, e.d});
               chk("R4 parity flag", {31'd0, pe_err}, {31'd0, e.pe});
               chk("R5 framing flag", {31'd0, fe_err}, {31'd0, e.fe});
            end
            data_read = 1'b1;
            @(negedge clk) data_read = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      // R12 reset state
      chk("R12 reset flags", {25'd0, rdrf, ovr, idle, fe_err, pe_err, rwu, rx_irq}, 32'd0);
      chk("R12 reset data", {23'd0, rx_data}, 32'd0);
      rst_n = 1'b1;
      auto_rd = 1;
      wait_bits(2);

      // R2 8-bit frames
      send(9'h055, 0, 0, 0, 1, 0, 1); wait_bits(2);
      send(9'h0A3, 0, 0, 0, 1, 0, 1); wait_bits(2);
      send(9'h000, 0, 0, 0, 1, 0, 1); wait_bits(2);
      send(9'h1FF, 0, 0, 0, 1, 0, 1); wait_bits(2);
      // R2 9-bit frames
      cfg_long_char = 1;
      send(9'h1A5, 0, 0, 0, 1, 0, 1); wait_bits(2);
      send(9'h0F0, 0, 0, 0, 1, 0, 1); wait_bits(2);
      send(9'h100, 0, 0, 0, 1, 0, 1); wait_bits(2);

      // R4 parity
      cfg_long_char = 0; cfg_par_en = 1; cfg_par_odd = 0;
      send(9'h035, 1, 0, 0, 1, 0, 1); wait_bits(2);
      send(9'h035, 1, 0, 1, 1, 0, 1); wait_bits(2);
      cfg_par_odd = 1;
      send(9'h035, 1, 1, 0, 1, 0, 1); wait_bits(2);
      cfg_long_char = 1;
      send(9'h0AA, 1, 1, 1, 1, 0, 1); wait_bits(2);
      cfg_long_char = 0; cfg_par_en = 0; cfg_par_odd = 0;

      // R5 framing error
      send(9'h03C, 0, 0, 0, 0, 0, 1); wait_bits(2);

      // R3 short low pulse is rejected
      @(negedge clk) rxd_pin = 1'b0;
      repeat (4 * TDIV) @(negedge clk);
      rxd_pin = 1'b1;
      wait_bits(2);
      chk("R3 glitch rejected", {31'd0, rdrf}, 32'd0);

      // R1 loop mode
      cfg_loop = 1;
      send(9'h06E, 0, 0, 0, 1, 1, 1); wait_bits(2);
      send(9'h012, 0, 0, 0, 1, 0, 0); wait_bits(1);
      chk("R1 pin ignored in loop", {31'd0, rdrf}, 32'd0);
      cfg_loop = 0;
      wait_bits(12); pulse_read();

      // R8 short idle rule
      cfg_idle_long = 0;
      send(9'h0FF, 0, 0, 0, 1, 0, 1);
      wait_bits(3);
      chk("R8 short idle flagged", {31'd0, idle}, 32'd1);
      pulse_read();
      wait_bits(12);
      chk("R8 idle once per period", {31'd0, idle}, 32'd0);
      // R8 long idle rule
      cfg_idle_long = 1;
      send(9'h0FF, 0, 0, 0, 1, 0, 1);
      wait_bits(3);
      chk("R8 long idle not yet", {31'd0, idle}, 32'd0);
      wait_bits(9);
      chk("R8 long idle flagged", {31'd0, idle}, 32'd1);
      cfg_idle_long = 0;
      pulse_read();

      // R6 / R7 overrun and interrupt masking
      auto_rd = 0; cfg_rie = 0;
      send(9'h011, 0, 0, 0, 1, 0, 0); wait_bits(1);
      chk("R7 irq masked", {31'd0, rx_irq}, 32'd0);
      chk("R2 full without read", {31'd0, rdrf}, 32'd1);
      send(9'h022, 0, 0, 0, 1, 0, 0); wait_bits(1);
      chk("R6 overrun flag", {31'd0, ovr}, 32'd1);
      chk("R6 first char kept", {23'd0, rx_data}, 32'h011);
      cfg_rie = 1;
      @(negedge clk);
      chk("R7 irq raised", {31'd0, rx_irq}, 32'd1);
      pulse_read();
      chk("R12 read clears", {29'd0, rdrf, ovr, rx_irq}, 32'd0);
      cfg_rie = 0;
      auto_rd = 1;
      wait_bits(12); pulse_read();

      // R9 / R10 sleep with idle wake
      cfg_wake_addr = 0;
      pulse_sleep();
      chk("R9 asleep", {31'd0, rwu}, 32'd1);
      send(9'h03C, 0, 0, 0, 1, 0, 0); wait_bits(1);
      chk("R9 no load asleep", {31'd0, rdrf}, 32'd0);
      wait_bits(12);
      chk("R10 idle wakes", {31'd0, rwu}, 32'd0);
      chk("R9 idle not flagged", {31'd0, idle}, 32'd0);
      send(9'h05A, 0, 0, 0, 1, 0, 1); wait_bits(12);
      pulse_read();

      // R11 address-mark wake, 8-bit
      cfg_wake_addr = 1;
      pulse_sleep();
      send(9'h005, 0, 0, 0, 1, 0, 0); wait_bits(12);
      chk("R11 idle does not wake", {31'd0, rwu}, 32'd1);
      chk("R9 idle frozen", {31'd0, idle}, 32'd0);
      send(9'h085, 0, 0, 0, 1, 0, 1); wait_bits(1);
      chk("R11 mark wakes", {31'd0, rwu}, 32'd0);
      wait_bits(1);
      // R11 address-mark wake, 9-bit
      cfg_long_char = 1;
      pulse_sleep();
      send(9'h0FF, 0, 0, 0, 1, 0, 0); wait_bits(1);
      chk("R11 bit8 clear stays asleep", {31'd0, rwu}, 32'd1);
      send(9'h100, 0, 0, 0, 1, 0, 1); wait_bits(1);
      chk("R11 bit8 mark wakes", {31'd0, rwu}, 32'd0);
      wait_bits(4);

      chk("R2 scoreboard drained", sb.size(), 32'd0);
      finish_run();
   end
endmodule